// File: doc/BRIEF.md
# Multi-Mode Preset Delay Timer

This block is a programmable time-delay element for a control-logic core. A free-running base tick, one pulse per 0.1 s made elsewhere from the system clock, is counted whenever the enable input is active. A two-bit mode input selects the behaviour:

- **On-delay:** the contact closes only after the enable input has been held for the first preset.
- **Off-delay:** the contact closes at once when enable is applied and opens once the first preset has run out.
- **Cyclic:** the contact alternates between an off interval set by the first preset and an on interval set by the second preset.
- **Idle:** the fourth code holds the element at rest.

Both presets are unsigned counts of 0.1 s ticks. A preset of zero counts as one tick, and any value above the upper limit (999 s, that is 9990 ticks) counts as that limit. A chain-done flag marks that the programmed interval has completed. Fed into the enable input of a second instance, it builds delays longer than one element can hold, for example 999 s followed by 201 s. The same connection gives a sequenced second output that follows a first one by a fixed delay.

Top module: `mode_delay_timer`

## Requirements
- R1: After reset the accumulated count is zero: in on-delay mode with a preset of one, applying enable without any tick leaves `contact_out` low.
- R2: In on-delay mode (`mode` = 2'b00), `contact_out` rises in the cycle after the edge that samples the N-th tick with enable held, where N is the effective first preset, and not before that edge.
- R3: In on-delay mode, releasing enable opens the contact in the same cycle and discards the accumulated ticks, so that a new activation needs the full preset again.
- R4: In off-delay mode (`mode` = 2'b01), `contact_out` is high in the same cycle that enable is applied. It goes low after N ticks and stays low while enable remains held. Releasing and reapplying enable closes the contact again.
- R5: In cyclic mode (`mode` = 2'b10), with enable held, the contact is low for A ticks, then high for B ticks, repeating, where A and B are the effective first and second presets. Releasing enable opens the contact at once, and the next activation begins with a full off interval.
- R6: A preset of 0 acts as 1 tick, and a preset above 9990 acts as 9990 ticks.
- R7: `chain_done` is high once the count has reached the first preset in the on-delay and off-delay modes, and during the on interval in cyclic mode. It is low whenever enable is low.
- R8: Clock edges without `tick` leave the accumulated count unchanged.
- R9: With `mode` = 2'b11 the contact and `chain_done` stay low and the count is held at zero, whatever the state of enable and tick.
- R10: A change of `mode` clears the accumulated count, so the new mode starts timing from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base time step, one-cycle pulse per 0.1 s |
| mode | input | 2 | 00 on-delay, 01 off-delay, 10 cyclic, 11 idle |
| delay_a | input | PW (14) | First preset in ticks (on-delay, off-delay, cyclic off interval) |
| delay_b | input | PW (14) | Second preset in ticks (cyclic on interval) |
| enable_in | input | 1 | Timer enable (coil) |
| contact_out | output | 1 | Output contact |
| chain_done | output | 1 | Interval complete, suitable to enable a following timer |

## Verification
The on-delay path is driven in three ways:

- an uninterrupted hold, which fixes the exact tick on which the contact closes;
- a hold broken one tick short, which shows whether a release truly discards time;
- a hold with a long tick-free gap, which tells edge counting apart from tick counting.

Off-delay and cyclic runs use unequal presets, so that exchanged presets or an off-by-one phase turn are visible. The cyclic run also breaks enable during an on interval. Zero and oversize presets probe the clamp at both ends. An idle-mode burst followed by a switch to another mode, and a switch in the middle of a count, show whether mode changes restart timing.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
   typedef enum logic [1:0] {
      MD_ON_DELAY  = 2'b00,
      MD_OFF_DELAY = 2'b01,
      MD_CYCLIC    = 2'b10,
      MD_IDLE      = 2'b11
   } mdt_mode_e;
endpackage

// File: rtl/mdt_preset_limit.sv
// Maps a raw preset onto the legal range [1, LIMIT_MAX].
module mdt_preset_limit #(
   parameter int PW        = 14,
   parameter int LIMIT_MAX = 9990
) (
   input  logic [PW-1:0] raw,
   output logic [PW-1:0] eff
);
   localparam logic [PW-1:0] TOP = PW'(LIMIT_MAX);
   localparam logic [PW-1:0] ONE = PW'(1);

   if (LIMIT_MAX < 1) begin : g_bad_min
      $error("mdt_preset_limit: LIMIT_MAX must be at least 1");
   end
   if (LIMIT_MAX >= (1 << PW)) begin : g_bad_width
      $error("mdt_preset_limit: LIMIT_MAX does not fit in PW bits");
   end

   always_comb begin
      if (raw == '0)
         eff = ONE;
      else if (raw > TOP)
         eff = TOP;
      else
         eff = raw;
   end
endmodule

// File: rtl/mdt_tick_counter.sv
// Tick accumulator and cyclic phase state.
module mdt_tick_counter
   import mdt_pkg::*;
#(
   parameter int PW        = 14,
   parameter int LIMIT_MAX = 9990
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  mdt_mode_e     mode,
   input  logic [PW-1:0] lim_a,
   input  logic [PW-1:0] lim_b,
   output logic          reached_a,
   output logic          phase_on
);
   localparam int CW = PW + 1;

   logic [PW-1:0] cnt;
   logic          phase;
   mdt_mode_e     mode_q;
   logic [CW-1:0] nxt;
   logic [CW-1:0] phase_lim;
   logic          restart;

   assign nxt       = {1'b0, cnt} + CW'(1);
   assign phase_lim = phase ? {1'b0, lim_b} : {1'b0, lim_a};
   assign restart   = !en || (mode != mode_q) || (mode == MD_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         phase  <= 1'b0;
         mode_q <= MD_ON_DELAY;
      end else begin
         mode_q <= mode;
         if (restart) begin
            cnt   <= '0;
            phase <= 1'b0;
         end else if (tick) begin
            unique case (mode)
               MD_ON_DELAY, MD_OFF_DELAY: begin
                  if (cnt < lim_a)
                     cnt <= nxt[PW-1:0];
               end
               MD_CYCLIC: begin
                  if (nxt >= phase_lim) begin
                     cnt   <= '0;
                     phase <= !phase;
                  end else begin
                     cnt <= nxt[PW-1:0];
                  end
               end
               default: cnt <= '0;
            endcase
         end
      end
   end

   assign reached_a = (cnt >= lim_a);
   assign phase_on  = phase;

   // R8: no tick, no change of the accumulated count
   a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && en && $stable(mode)) |=> $stable(cnt));
   // R3: a released enable leaves nothing accumulated
   a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0 && !phase));
   // R10: a mode switch restarts timing
   a_r10_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |=> (cnt == '0));
   // R6: the count never passes the clamp limit
   a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(LIMIT_MAX));
endmodule

// File: rtl/mdt_contact_stage.sv
// Contact and chain decode, optionally registered.
module mdt_contact_stage
   import mdt_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  mdt_mode_e mode,
   input  logic      en,
   input  logic      reached_a,
   input  logic      phase_on,
   output logic      contact,
   output logic      chain
);
   logic c_d;
   logic k_d;

   always_comb begin
      c_d = 1'b0;
      k_d = 1'b0;
      unique case (mode)
         MD_ON_DELAY: begin
            c_d = en && reached_a;
            k_d = en && reached_a;
         end
         MD_OFF_DELAY: begin
            c_d = en && !reached_a;
            k_d = en && reached_a;
         end
         MD_CYCLIC: begin
            c_d = en && phase_on;
            k_d = en && phase_on;
         end
         default: begin
            c_d = 1'b0;
            k_d = 1'b0;
         end
      endcase
   end

   if (REG_OUT) begin : g_reg
      logic c_q;
      logic k_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= 1'b0;
            k_q <= 1'b0;
         end else begin
            c_q <= c_d;
            k_q <= k_d;
         end
      end
      assign contact = c_q;
      assign chain   = k_q;
   end else begin : g_comb
      assign contact = c_d;
      assign chain   = k_d;
   end
endmodule

// File: rtl/mode_delay_timer.sv
module mode_delay_timer
   import mdt_pkg::*;
#(
   parameter int PW         = 14,
   parameter int PRESET_MAX = 9990,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [1:0]    mode,
   input  logic [PW-1:0] delay_a,
   input  logic [PW-1:0] delay_b,
   input  logic          enable_in,
   output logic          contact_out,
   output logic          chain_done
);
   localparam int NPRE = 2;

   if (PW < 2) begin : g_bad_pw
      $error("mode_delay_timer: PW must be at least 2");
   end

   mdt_mode_e     mode_e;
   logic [PW-1:0] raw_pre [NPRE];
   logic [PW-1:0] eff_pre [NPRE];
   logic          reached_a;
   logic          phase_on;

   assign mode_e     = mdt_mode_e'(mode);
   assign raw_pre[0] = delay_a;
   assign raw_pre[1] = delay_b;

   for (genvar i = 0; i < NPRE; i++) begin : g_lim
      mdt_preset_limit #(.PW(PW), .LIMIT_MAX(PRESET_MAX)) u_lim (
         .raw (raw_pre[i]),
         .eff (eff_pre[i])
      );
   end

   mdt_tick_counter #(.PW(PW), .LIMIT_MAX(PRESET_MAX)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .en        (enable_in),
      .mode      (mode_e),
      .lim_a     (eff_pre[0]),
      .lim_b     (eff_pre[1]),
      .reached_a (reached_a),
      .phase_on  (phase_on)
   );

   mdt_contact_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_e),
      .en        (enable_in),
      .reached_a (reached_a),
      .phase_on  (phase_on),
      .contact   (contact_out),
      .chain     (chain_done)
   );

   if (!REG_OUT) begin : g_port_checks
      // R7 and R5: nothing is driven while enable is low
      a_r7_dark_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
         !enable_in |-> (!contact_out && !chain_done));
      // R4: off-delay contact closes together with enable
      a_r4_off_delay_immediate: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'b01 && $rose(enable_in)) |-> contact_out);
      // R2: an on-delay contact only closes after a counted tick
      a_r2_close_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'b00 && $stable(mode) && $stable(delay_a) && $rose(contact_out))
            |-> $past(tick));
      // R9: idle code keeps both outputs low
      a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'b11) |-> (!contact_out && !chain_done));
   end
endmodule

// File: tb/sim_mode_delay_timer.sv
`timescale 1ns/1ps
module sim_mode_delay_timer;
   localparam int PW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [PW-1:0] delay_a = '0;
   logic [PW-1:0] delay_b = '0;
   logic          enable_in = 1'b0;
   logic          contact_out;
   logic          chain_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mode_delay_timer #(.PW(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
      .delay_a(delay_a), .delay_b(delay_b), .enable_in(enable_in),
      .contact_out(contact_out), .chain_done(chain_done)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         tick = 1'b1;
         @(posedge clk);
         #1;
         tick = 1'b0;
      end
   endtask

   task automatic set_en(logic v);
      enable_in = v;
      #1;
   endtask

   task automatic quiesce();
      set_en(1'b0);
      idle(2);
   endtask

   task automatic t_reset();
      mode = 2'b00; delay_a = 14'd1;
      set_en(1'b1);
      chk("R1", "contact after reset, no tick", contact_out, 1'b0);
      chk("R1", "chain after reset, no tick", chain_done, 1'b0);
      idle(3);
      chk("R1", "contact with idle edges", contact_out, 1'b0);
      quiesce();
   endtask

   task automatic t_on_delay();
      mode = 2'b00; delay_a = 14'd5; idle(1);
      set_en(1'b1);
      ticks(4);
      chk("R2", "contact after 4 of 5 ticks", contact_out, 1'b0);
      chk("R7", "chain before preset", chain_done, 1'b0);
      ticks(1);
      chk("R2", "contact after 5 ticks", contact_out, 1'b1);
      chk("R7", "chain at preset", chain_done, 1'b1);
      ticks(3);
      chk("R2", "contact stays closed", contact_out, 1'b1);
      set_en(1'b0);
      chk("R3", "contact opens with enable", contact_out, 1'b0);
      chk("R7", "chain drops with enable", chain_done, 1'b0);
      idle(1);
   endtask

   task automatic t_on_abort();
      mode = 2'b00; delay_a = 14'd5; idle(1);
      set_en(1'b1);
      ticks(4);
      set_en(1'b0);
      idle(1);
      set_en(1'b1);
      ticks(4);
      chk("R3", "restarted count not yet done", contact_out, 1'b0);
      ticks(1);
      chk("R3", "restarted count done", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_no_tick();
      mode = 2'b00; delay_a = 14'd3; idle(1);
      set_en(1'b1);
      ticks(2);
      idle(20);
      chk("R8", "edges without tick do not count", contact_out, 1'b0);
      ticks(1);
      chk("R8", "count kept across gap", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_off_delay();
      mode = 2'b01; delay_a = 14'd4; idle(1);
      set_en(1'b1);
      chk("R4", "contact closes with enable", contact_out, 1'b1);
      chk("R7", "off-delay chain low at start", chain_done, 1'b0);
      ticks(3);
      chk("R4", "contact before 4th tick", contact_out, 1'b1);
      ticks(1);
      chk("R4", "contact after 4th tick", contact_out, 1'b0);
      chk("R7", "off-delay chain at preset", chain_done, 1'b1);
      ticks(6);
      chk("R4", "contact stays open while held", contact_out, 1'b0);
      set_en(1'b0);
      idle(1);
      set_en(1'b1);
      chk("R4", "reapplied enable closes again", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_cyclic();
      mode = 2'b10; delay_a = 14'd3; delay_b = 14'd2; idle(1);
      set_en(1'b1);
      for (int c = 0; c < 2; c++) begin
         ticks(2);
         chk("R5", "off interval before 3rd tick", contact_out, 1'b0);
         ticks(1);
         chk("R5", "on after off interval", contact_out, 1'b1);
         chk("R7", "chain in on interval", chain_done, 1'b1);
         ticks(1);
         chk("R5", "on interval midway", contact_out, 1'b1);
         ticks(1);
         chk("R5", "off after on interval", contact_out, 1'b0);
      end
      ticks(3);
      chk("R5", "on again before break", contact_out, 1'b1);
      set_en(1'b0);
      chk("R5", "break opens contact", contact_out, 1'b0);
      idle(1);
      set_en(1'b1);
      ticks(2);
      chk("R5", "restart begins with off interval", contact_out, 1'b0);
      ticks(1);
      chk("R5", "restart on after full off", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_zero_preset();
      mode = 2'b00; delay_a = 14'd0; idle(1);
      set_en(1'b1);
      chk("R6", "zero preset not instant", contact_out, 1'b0);
      ticks(1);
      chk("R6", "zero preset acts as one tick", contact_out, 1'b1);
      quiesce();
      mode = 2'b10; delay_a = 14'd0; delay_b = 14'd0; idle(1);
      set_en(1'b1);
      ticks(1);
      chk("R6", "cyclic zero presets on", contact_out, 1'b1);
      ticks(1);
      chk("R6", "cyclic zero presets off", contact_out, 1'b0);
      quiesce();
   endtask

   task automatic t_big_preset();
      mode = 2'b00; delay_a = 14'd16383; idle(1);
      set_en(1'b1);
      ticks(9989);
      chk("R6", "oversize preset at 9989 ticks", contact_out, 1'b0);
      ticks(1);
      chk("R6", "oversize preset clamps to 9990", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_idle_mode();
      mode = 2'b11; delay_a = 14'd2; idle(1);
      set_en(1'b1);
      ticks(5);
      chk("R9", "idle contact", contact_out, 1'b0);
      chk("R9", "idle chain", chain_done, 1'b0);
      mode = 2'b00;
      idle(1);
      ticks(1);
      chk("R9", "idle left count at zero", contact_out, 1'b0);
      ticks(1);
      chk("R9", "count from zero after idle", contact_out, 1'b1);
      quiesce();
   endtask

   task automatic t_mode_switch();
      mode = 2'b00; delay_a = 14'd5; idle(1);
      set_en(1'b1);
      ticks(3);
      mode = 2'b01;
      #1;
      chk("R10", "off-delay contact right after switch", contact_out, 1'b1);
      idle(1);
      ticks(4);
      chk("R10", "switch cleared count, still closed", contact_out, 1'b1);
      ticks(1);
      chk("R10", "opens after full preset", contact_out, 1'b0);
      quiesce();
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_on_delay();
      t_on_abort();
      t_no_tick();
      t_off_delay();
      t_cyclic();
      t_zero_preset();
      t_big_preset();
      t_idle_mode();
      t_mode_switch();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule